// File: doc/BRIEF.md
# Speculation Shadow and Kill Matrix

This block keeps track of which function units are still under speculation and so must not write results yet. Three kinds of speculative producer can hold such a shadow: branch units, units that may raise an exception, and predicate elements whose mask bit is not yet known. Each producer owns one shadow source. When a function unit is issued, the issue logic tells the block which sources the new operation depends on. The block keeps one bit for each pair of source and function unit.

A source ends its shadow with either a success or a fail. On success it drops every bit it holds, and a unit becomes writeable once no source holds it. On fail, every unit it covers receives a one-cycle kill pulse, which its computation stage also consumes, and all shadow bits of that unit are dropped. A predicate decoder turns a decoded mask into per-element success (bit 1) or fail (bit 0). A fence input, raised for speculation barriers, exceptions and interrupts, clears the whole matrix and cancels pending kills.

Top module: `spec_shadow_matrix`

## Requirements
- R1: After reset, every `wr_ok_o` bit is 1 and every `die_o` bit is 0.
- R2: The source index space is: branch sources at 0..NUM_BR-1, exception sources at NUM_BR..NUM_BR+NUM_EXC-1, and predicate elements after those. An issue with `issue_shadow_i` bit s set places a hold by source s on unit `issue_fu_i`. From the next cycle, `wr_ok_o` for that unit is 0.
- R3: A success from a source releases its holds. A unit returns to `wr_ok_o`=1 in the cycle after the last source holding it succeeds, and stays 0 while any source still holds it.
- R4: A fail from a source gives a `die_o` pulse of exactly one cycle, in the cycle after the fail, on every unit that source holds, and on no other unit.
- R5: A killed unit shows `wr_ok_o`=0 during its kill pulse. After the pulse it shows 1, because all its holds from every source were cleared together with the kill.
- R6: If success and fail arrive together for one source, the fail takes effect.
- R7: While `pred_valid_i` is 1, mask bit e acts as success (1) or fail (0) for predicate element source NUM_BR+NUM_EXC+e.
- R8: `fence_i` clears all holds and all pending kills. In the next cycle every `wr_ok_o` bit is 1 and every `die_o` bit is 0, even if a fail arrives in the same cycle.
- R9: An issue bit for a source that resolves in the same cycle places no hold and causes no kill.
- R10: An issue to a unit in the same cycle as that unit is killed places no hold. The unit is writeable once the kill pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fence_i | input | 1 | Cancel all speculation |
| issue_valid_i | input | 1 | An operation issues this cycle |
| issue_fu_i | input | FUW | Index of the issuing unit |
| issue_shadow_i | input | NSRC | Sources the issuing operation depends on |
| br_ok_i | input | NUM_BR | Branch source success |
| br_fail_i | input | NUM_BR | Branch source fail |
| exc_ok_i | input | NUM_EXC | Exception source success (cannot trap) |
| exc_fail_i | input | NUM_EXC | Exception source fail (trap taken) |
| pred_valid_i | input | 1 | Predicate mask decoded this cycle |
| pred_mask_i | input | NUM_PEL | Predicate mask, one bit per element |
| wr_ok_o | output | NUM_FU | Unit is free of every shadow |
| die_o | output | NUM_FU | One-cycle kill command per unit |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A hold, a release, a kill pulse and a fence all take effect at the register update, and `wr_ok_o` is decoded directly from the stored matrix. The bench changes inputs just after a falling edge and samples outputs at the next falling edge, which lies after exactly one rising edge. For kill pulses it samples one further falling edge later to confirm that the pulse has ended and the unit is writeable again.

// File: rtl/shadow_pkg.sv
// Shared helpers for the speculation shadow matrix.
// Assumes sources are packed as branch, then exception, then predicate element.
package shadow_pkg;
    // Total number of shadow sources for a given mix of producers.
    function automatic int src_total(input int nb, input int ne, input int np);
        return nb + ne + np;
    endfunction

    // Index of the first exception source.
    function automatic int exc_base(input int nb);
        return nb;
    endfunction

    // Index of the first predicate element source.
    function automatic int pel_base(input int nb, input int ne);
        return nb + ne;
    endfunction
endpackage

// File: rtl/shadow_pred_decode.sv
// Turns a decoded predicate mask into per-element success and fail strobes.
// Assumes the mask is only meaningful while valid is high.
module shadow_pred_decode #(
    parameter int NUM_PEL = 4
) (
    input  logic               valid_i,
    input  logic [NUM_PEL-1:0] mask_i,
    output logic [NUM_PEL-1:0] ok_o,
    output logic [NUM_PEL-1:0] fail_o
);
    // A set bit releases its element, a clear bit kills it.
    always_comb begin
        ok_o   = valid_i ? mask_i  : '0;
        fail_o = valid_i ? ~mask_i : '0;
    end
endmodule

// File: rtl/shadow_resolve.sv
// Merges raw success and fail strobes into release and kill vectors.
// Fail takes priority over success, and a fence turns every source into a
// release with no kill.
module shadow_resolve #(
    parameter int NSRC = 8
) (
    input  logic            fence_i,
    input  logic [NSRC-1:0] ok_i,
    input  logic [NSRC-1:0] fail_i,
    output logic [NSRC-1:0] rel_o,
    output logic [NSRC-1:0] kill_o
);
    // Resolution per source; a fence suppresses kills.
    always_comb begin
        if (fence_i) begin
            rel_o  = '1;
            kill_o = '0;
        end else begin
            rel_o  = ok_i | fail_i;
            kill_o = fail_i;
        end
    end
endmodule

// File: rtl/shadow_column.sv
// One function unit's column of the shadow matrix: a hold bit per source,
// plus the registered kill pulse. Assumes the release and kill vectors are
// already resolved, so a kill is also a release.
module shadow_column #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fence_i,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] rel_i,
    input  logic [NSRC-1:0] kill_i,
    output logic            wr_ok_o,
    output logic            die_o
);
    logic [NSRC-1:0] hold_q;
    logic            die_q;
    logic            hit;

    // The unit is killed if any failing source holds it.
    always_comb hit = |(hold_q & kill_i);

    // Hold bits and kill pulse update; kill clears the whole column.
    always_ff @(posedge clk) begin
        if (!rst_n || fence_i) begin
            hold_q <= '0;
            die_q  <= 1'b0;
        end else if (hit) begin
            hold_q <= '0;
            die_q  <= 1'b1;
        end else begin
            hold_q <= (hold_q | set_i) & ~rel_i;
            die_q  <= 1'b0;
        end
    end

    // Writeable only with no hold and no kill in progress.
    always_comb begin
        wr_ok_o = ~(|hold_q) & ~die_q;
        die_o   = die_q;
    end
endmodule

// File: rtl/spec_shadow_matrix.sv
// Speculation shadow matrix: sources by function units. Branch, exception and
// predicate element sources hold units; success releases, fail kills.
// Assumes issue logic names the sources an operation depends on at issue.
module spec_shadow_matrix #(
    parameter int NUM_FU  = 8,
    parameter int NUM_BR  = 2,
    parameter int NUM_EXC = 2,
    parameter int NUM_PEL = 4,
    localparam int NSRC   = shadow_pkg::src_total(NUM_BR, NUM_EXC, NUM_PEL),
    localparam int FUW    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fence_i,
    input  logic               issue_valid_i,
    input  logic [FUW-1:0]     issue_fu_i,
    input  logic [NSRC-1:0]    issue_shadow_i,
    input  logic [NUM_BR-1:0]  br_ok_i,
    input  logic [NUM_BR-1:0]  br_fail_i,
    input  logic [NUM_EXC-1:0] exc_ok_i,
    input  logic [NUM_EXC-1:0] exc_fail_i,
    input  logic               pred_valid_i,
    input  logic [NUM_PEL-1:0] pred_mask_i,
    output logic [NUM_FU-1:0]  wr_ok_o,
    output logic [NUM_FU-1:0]  die_o
);
    logic [NUM_PEL-1:0] pel_ok, pel_fail;
    logic [NSRC-1:0]    raw_ok, raw_fail, rel, kill;

    shadow_pred_decode #(.NUM_PEL(NUM_PEL)) u_pred (
        .valid_i (pred_valid_i),
        .mask_i  (pred_mask_i),
        .ok_o    (pel_ok),
        .fail_o  (pel_fail)
    );

    // Pack sources as branch, exception, predicate element (low to high).
    always_comb begin
        raw_ok   = {pel_ok,   exc_ok_i,   br_ok_i};
        raw_fail = {pel_fail, exc_fail_i, br_fail_i};
    end

    shadow_resolve #(.NSRC(NSRC)) u_res (
        .fence_i (fence_i),
        .ok_i    (raw_ok),
        .fail_i  (raw_fail),
        .rel_o   (rel),
        .kill_o  (kill)
    );

    for (genvar f = 0; f < NUM_FU; f++) begin : g_col
        logic [NSRC-1:0] set_f;

        // Issue bits reach only the addressed unit's column.
        always_comb set_f = (issue_valid_i && (issue_fu_i == FUW'(f))) ? issue_shadow_i : '0;

        shadow_column #(.NSRC(NSRC)) u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .fence_i (fence_i),
            .set_i   (set_f),
            .rel_i   (rel),
            .kill_i  (kill),
            .wr_ok_o (wr_ok_o[f]),
            .die_o   (die_o[f])
        );
    end
endmodule

// File: rtl/spec_shadow_matrix_chk.sv
// Port-level property checker for spec_shadow_matrix, attached by bind.
module spec_shadow_matrix_chk #(
    parameter int NUM_FU  = 8,
    parameter int NUM_BR  = 2,
    parameter int NUM_EXC = 2,
    parameter int NUM_PEL = 4,
    parameter int NSRC    = 8,
    parameter int FUW     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fence_i,
    input logic               issue_valid_i,
    input logic [FUW-1:0]     issue_fu_i,
    input logic [NSRC-1:0]    issue_shadow_i,
    input logic [NUM_BR-1:0]  br_ok_i,
    input logic [NUM_BR-1:0]  br_fail_i,
    input logic [NUM_EXC-1:0] exc_ok_i,
    input logic [NUM_EXC-1:0] exc_fail_i,
    input logic               pred_valid_i,
    input logic [NUM_PEL-1:0] pred_mask_i,
    input logic [NUM_FU-1:0]  wr_ok_o,
    input logic [NUM_FU-1:0]  die_o
);
    logic any_fail, any_res;
    always_comb begin
        any_fail = (|br_fail_i) || (|exc_fail_i) || (pred_valid_i && !(&pred_mask_i));
        any_res  = any_fail || (|br_ok_i) || (|exc_ok_i) || pred_valid_i;
    end

    AST_FENCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fence_i |=> (die_o == '0) && (&wr_ok_o)); // R8

    AST_HOLD_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && (|issue_shadow_i) && !any_res && !fence_i)
        |=> !wr_ok_o[$past(issue_fu_i)]); // R2

    AST_DIE_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (die_o != '0) |-> $past(any_fail)); // R4

    AST_DIE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (die_o != '0) |=> ((die_o & $past(die_o)) == '0)); // R4

    AST_DIE_NOT_WRITEABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (die_o != '0) |-> ((die_o & wr_ok_o) == '0)); // R5
endmodule

bind spec_shadow_matrix spec_shadow_matrix_chk #(
    .NUM_FU(NUM_FU), .NUM_BR(NUM_BR), .NUM_EXC(NUM_EXC),
    .NUM_PEL(NUM_PEL), .NSRC(NSRC), .FUW(FUW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fence_i(fence_i),
    .issue_valid_i(issue_valid_i), .issue_fu_i(issue_fu_i),
    .issue_shadow_i(issue_shadow_i), .br_ok_i(br_ok_i), .br_fail_i(br_fail_i),
    .exc_ok_i(exc_ok_i), .exc_fail_i(exc_fail_i), .pred_valid_i(pred_valid_i),
    .pred_mask_i(pred_mask_i), .wr_ok_o(wr_ok_o), .die_o(die_o)
);

// File: tb/spec_shadow_matrix_test.sv
// Directed bench: inputs change after a falling edge, outputs are sampled at
// the next falling edge (one rising edge later).
module spec_shadow_matrix_test;
    localparam int CLK_PERIOD = 10;
    // Source indices with defaults: br 0..1, exc 2..3, predicate elements 4..7.

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fence_i, issue_valid_i, pred_valid_i;
    logic [2:0] issue_fu_i;
    logic [7:0] issue_shadow_i;
    logic [1:0] br_ok_i, br_fail_i, exc_ok_i, exc_fail_i;
    logic [3:0] pred_mask_i;
    logic [7:0] wr_ok_o, die_o;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_shadow_matrix uut (
        .clk(clk), .rst_n(rst_n), .fence_i(fence_i),
        .issue_valid_i(issue_valid_i), .issue_fu_i(issue_fu_i),
        .issue_shadow_i(issue_shadow_i), .br_ok_i(br_ok_i), .br_fail_i(br_fail_i),
        .exc_ok_i(exc_ok_i), .exc_fail_i(exc_fail_i), .pred_valid_i(pred_valid_i),
        .pred_mask_i(pred_mask_i), .wr_ok_o(wr_ok_o), .die_o(die_o)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic quiet();
        fence_i = 0; issue_valid_i = 0; issue_fu_i = 0; issue_shadow_i = 0;
        br_ok_i = 0; br_fail_i = 0; exc_ok_i = 0; exc_fail_i = 0;
        pred_valid_i = 0; pred_mask_i = 0;
    endtask

    task automatic step();
        @(negedge clk);
        quiet();
    endtask

    task automatic issue(input int fu, input logic [7:0] m);
        issue_valid_i = 1; issue_fu_i = 3'(fu); issue_shadow_i = m;
        step();
    endtask

    task automatic t_reset();
        check("R1 wr_ok after reset", wr_ok_o, 8'hFF);
        check("R1 die after reset", die_o, 8'h00);
    endtask

    task automatic t_hold_release();
        issue(2, 8'h01);                       // fu2 under br0
        check("R2 fu2 held", wr_ok_o, 8'hFB);
        issue(3, 8'h06);                       // fu3 under br1, exc0
        check("R2 fu3 held", wr_ok_o, 8'hF3);
        br_ok_i = 2'b10; step();
        check("R3 fu3 still held by exc0", wr_ok_o, 8'hF3);
        exc_ok_i = 2'b01; step();
        check("R3 fu3 released", wr_ok_o, 8'hFB);
        br_ok_i = 2'b01; step();
        check("R3 fu2 released", wr_ok_o, 8'hFF);
        check("R3 no kill on success", die_o, 8'h00);
    endtask

    task automatic t_fail_kill();
        issue(1, 8'h01);                       // br0
        issue(5, 8'h09);                       // br0 + exc1
        issue(6, 8'h02);                       // br1
        br_fail_i = 2'b01; step();
        check("R4 kill pulse", die_o, 8'h22);
        check("R5 killed not writeable", wr_ok_o, 8'h9D);
        step();
        check("R4 pulse one cycle", die_o, 8'h00);
        check("R5 killed units writeable after", wr_ok_o, 8'hBF);
        br_ok_i = 2'b10; step();
        check("R3 fu6 released", wr_ok_o, 8'hFF);
    endtask

    task automatic t_fail_wins();
        issue(0, 8'h04);                       // exc0
        exc_ok_i = 2'b01; exc_fail_i = 2'b01; step();
        check("R6 fail wins", die_o, 8'h01);
        step();
        check("R6 after pulse", wr_ok_o, 8'hFF);
    endtask

    task automatic t_pred();
        issue(4, 8'h10);                       // element 0
        issue(7, 8'h20);                       // element 1
        issue(2, 8'h40);                       // element 2
        check("R7 held before mask", wr_ok_o, 8'h6B);
        pred_valid_i = 1; pred_mask_i = 4'b0101; step();
        check("R7 element 1 killed", die_o, 8'h80);
        check("R7 elements 0,2 released", wr_ok_o, 8'h7F);
        step();
        check("R7 done", wr_ok_o, 8'hFF);
    endtask

    task automatic t_fence();
        issue(0, 8'h01);
        issue(1, 8'h05);
        fence_i = 1; br_fail_i = 2'b01; step();
        check("R8 fence no kill", die_o, 8'h00);
        check("R8 fence clears holds", wr_ok_o, 8'hFF);
    endtask

    task automatic t_same_cycle();
        br_ok_i = 2'b10; issue(3, 8'h02);
        check("R9 issue with same-cycle success", wr_ok_o, 8'hFF);
        br_fail_i = 2'b10; issue(3, 8'h02);
        check("R9 issue with same-cycle fail no kill", die_o, 8'h00);
        check("R9 issue with same-cycle fail no hold", wr_ok_o, 8'hFF);
    endtask

    task automatic t_issue_during_kill();
        issue(1, 8'h01);
        br_fail_i = 2'b01; issue(1, 8'h02);    // kill fu1, reissue under br1
        check("R10 kill pulse", die_o, 8'h02);
        step();
        check("R10 reissue dropped", wr_ok_o, 8'hFF);
    endtask

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_hold_release();
        t_fail_kill();
        t_fail_wins();
        t_pred();
        t_fence();
        t_same_cycle();
        t_issue_during_kill();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule